// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a pixel clock into the raster timing of a display: horizontal sync, vertical sync, a data-enable strobe and the column and row of the pixel currently in the visible area. Each axis is described by four programmable intervals (sync pulse, back porch, active data, front porch), and every interval value is written as its length in clocks (horizontal) or lines (vertical) minus one. The sync and data-enable outputs each have their own polarity selection.

A single run control starts and stops the raster. While stopped, the outputs sit at their inactive levels and both counters park at the first cycle of vertical sync, so every start begins a clean frame. A one-cycle frame event marks the first pixel clock of each frame, for use by interrupt logic. Pixel fetching and colour processing are handled elsewhere. The configuration is expected to stay static while the raster runs.

Top module: `vtg_top`

## Requirements
- R1: Each interval input holds the interval length minus one: a value of N makes that phase last N+1 pixel clocks (horizontal) or N+1 lines (vertical).
- R2: Horizontally the phases run in the order sync, back porch, data, front porch, then wrap to sync; a line lasts the sum of the four horizontal lengths.
- R3: Polarity select bit 0 governs vsync_o, bit 1 hsync_o and bit 2 de_o; a set bit makes that output high when active and low when inactive, a clear bit the reverse.
- R4: While run_en is low, hsync_o, vsync_o and de_o are at their inactive levels and px_x_o, px_y_o and frame_evt_o are zero in the same cycle, and both counters return to the start of vertical sync at the next clock edge.
- R5: In the first cycle with run_en high, before any clock edge has seen it high, the outputs show the first pixel of horizontal sync on the first line of vertical sync; a run stopped mid-frame restarts from that point.
- R6: The vertical position advances by one line exactly when a horizontal line completes, and the vertical phases follow the order sync, back porch, data, front porch.
- R7: frame_evt_o is high for exactly one cycle per frame, in the first cycle of the first line of vertical sync.
- R8: de_o is at its active level only when both the horizontal and vertical positions are in their data phases.
- R9: px_x_o and px_y_o give the zero-based offset within the horizontal and vertical data phases; each reads zero outside its data phase.
- R10: While the synchronous reset rst is high, all outputs are at their inactive levels and frame_evt_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control, 1 runs the raster |
| pol_sel | input | 3 | Polarity: bit 0 vsync, bit 1 hsync, bit 2 data enable; 1 is active-high |
| h_sync_m1 | input | AXIS_W | Horizontal sync length minus one |
| h_back_m1 | input | AXIS_W | Horizontal back porch length minus one |
| h_data_m1 | input | AXIS_W | Horizontal active width minus one |
| h_front_m1 | input | AXIS_W | Horizontal front porch length minus one |
| v_sync_m1 | input | AXIS_W | Vertical sync lines minus one |
| v_back_m1 | input | AXIS_W | Vertical back porch lines minus one |
| v_data_m1 | input | AXIS_W | Vertical active height minus one |
| v_front_m1 | input | AXIS_W | Vertical front porch lines minus one |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| px_x_o | output | AXIS_W | Column inside the active area |
| px_y_o | output | AXIS_W | Row inside the active area |
| frame_evt_o | output | 1 | One-cycle pulse at the start of each frame |

## Verification
All outputs are decoded combinationally from the two counter registers and run_en, so a change of run_en shows in the same cycle, and each clock edge with run_en high moves the raster by exactly one pixel. The bench drives run_en just after a falling edge and samples a moment later, so the sample taken after k rising edges of running must show raster position k, computed arithmetically from the programmed lengths as column k modulo the line length and line k divided by the line length, modulo the frame height. Stopping is checked in the same cycle it is requested, and the parked state is then checked by restarting and expecting position zero.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    parameter int AXIS_W = 12;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_DATA  = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef struct packed {
        logic [AXIS_W-1:0] sync_m1;
        logic [AXIS_W-1:0] back_m1;
        logic [AXIS_W-1:0] data_m1;
        logic [AXIS_W-1:0] front_m1;
    } axis_cfg_t;

    // bit 2 data enable, bit 1 hsync, bit 0 vsync
    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } pol_t;

    function automatic logic [AXIS_W-1:0] phase_limit(axis_cfg_t c, phase_e p);
        case (p)
            PH_SYNC:  return c.sync_m1;
            PH_BACK:  return c.back_m1;
            PH_DATA:  return c.data_m1;
            default:  return c.front_m1;
        endcase
    endfunction

    function automatic phase_e phase_next(phase_e p);
        case (p)
            PH_SYNC:  return PH_BACK;
            PH_BACK:  return PH_DATA;
            PH_DATA:  return PH_FRONT;
            default:  return PH_SYNC;
        endcase
    endfunction

    function automatic logic drive_level(logic active, logic act_high);
        return active ? act_high : ~act_high;
    endfunction

endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  axis_cfg_t         cfg,
    output phase_e            phase_o,
    output logic [AXIS_W-1:0] cnt_o,
    output logic              wrap_o
);

    phase_e            phase_q;
    logic [AXIS_W-1:0] cnt_q;
    logic              at_end;

    assign at_end  = cnt_q >= phase_limit(cfg, phase_q);
    assign wrap_o  = step && at_end && (phase_q == PH_FRONT);
    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else if (step) begin
            if (at_end) begin
                phase_q <= phase_next(phase_q);
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2 R6
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && (phase_q != $past(phase_q))) |-> (phase_q == phase_next($past(phase_q))));

    // R1
    fresh_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && (phase_q != $past(phase_q))) |-> (cnt_q == '0));

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && !$past(step)) |-> ($stable(cnt_q) && $stable(phase_q)));

endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
    import vtg_pkg::*;
(
    input  logic              active,
    input  pol_t              pol,
    input  phase_e            h_phase,
    input  logic [AXIS_W-1:0] h_cnt,
    input  phase_e            v_phase,
    input  logic [AXIS_W-1:0] v_cnt,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [AXIS_W-1:0] px_x_o,
    output logic [AXIS_W-1:0] px_y_o,
    output logic              frame_evt_o
);

    logic h_in_data;
    logic v_in_data;
    logic hs_act;
    logic vs_act;
    logic de_act;

    always_comb begin
        h_in_data   = active && (h_phase == PH_DATA);
        v_in_data   = active && (v_phase == PH_DATA);
        hs_act      = active && (h_phase == PH_SYNC);
        vs_act      = active && (v_phase == PH_SYNC);
        de_act      = h_in_data && v_in_data;
        hsync_o     = drive_level(hs_act, pol.hs);
        vsync_o     = drive_level(vs_act, pol.vs);
        de_o        = drive_level(de_act, pol.de);
        px_x_o      = h_in_data ? h_cnt : '0;
        px_y_o      = v_in_data ? v_cnt : '0;
        frame_evt_o = hs_act && vs_act && (h_cnt == '0) && (v_cnt == '0);
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [2:0]        pol_sel,
    input  logic [AXIS_W-1:0] h_sync_m1,
    input  logic [AXIS_W-1:0] h_back_m1,
    input  logic [AXIS_W-1:0] h_data_m1,
    input  logic [AXIS_W-1:0] h_front_m1,
    input  logic [AXIS_W-1:0] v_sync_m1,
    input  logic [AXIS_W-1:0] v_back_m1,
    input  logic [AXIS_W-1:0] v_data_m1,
    input  logic [AXIS_W-1:0] v_front_m1,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [AXIS_W-1:0] px_x_o,
    output logic [AXIS_W-1:0] px_y_o,
    output logic              frame_evt_o
);

    axis_cfg_t         h_cfg;
    axis_cfg_t         v_cfg;
    pol_t              pol;
    phase_e            h_phase;
    phase_e            v_phase;
    logic [AXIS_W-1:0] h_cnt;
    logic [AXIS_W-1:0] v_cnt;
    logic              line_done;
    logic              frame_done;
    logic              active;

    assign h_cfg  = '{sync_m1: h_sync_m1, back_m1: h_back_m1,
                      data_m1: h_data_m1, front_m1: h_front_m1};
    assign v_cfg  = '{sync_m1: v_sync_m1, back_m1: v_back_m1,
                      data_m1: v_data_m1, front_m1: v_front_m1};
    assign pol    = pol_t'(pol_sel);
    assign active = run_en && !rst;

    vtg_axis_counter h_axis_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run_en),
        .step    (run_en),
        .cfg     (h_cfg),
        .phase_o (h_phase),
        .cnt_o   (h_cnt),
        .wrap_o  (line_done)
    );

    vtg_axis_counter v_axis_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run_en),
        .step    (line_done),
        .cfg     (v_cfg),
        .phase_o (v_phase),
        .cnt_o   (v_cnt),
        .wrap_o  (frame_done)
    );

    vtg_out_stage out_i (
        .active      (active),
        .pol         (pol),
        .h_phase     (h_phase),
        .h_cnt       (h_cnt),
        .v_phase     (v_phase),
        .v_cnt       (v_cnt),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .px_x_o      (px_x_o),
        .px_y_o      (px_y_o),
        .frame_evt_o (frame_evt_o)
    );

    // R7
    evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_evt_o |=> !frame_evt_o);

    // R4
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!run_en) |-> (h_phase == PH_SYNC && h_cnt == '0 &&
                            v_phase == PH_SYNC && v_cnt == '0));

    // R6
    v_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((v_cnt != $past(v_cnt)) || (v_phase != $past(v_phase))) |-> ($past(line_done) || $past(!run_en)));

    // R8
    de_clear_of_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && (de_o == pol.de)) |-> ((hsync_o != pol.hs) && (vsync_o != pol.vs)));

    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_done) && $past(run_en)) |-> (v_phase == PH_SYNC && v_cnt == '0 && frame_evt_o == run_en));

endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic         run_en;
    logic [2:0]   pol_sel;
    logic [W-1:0] h_sync_m1, h_back_m1, h_data_m1, h_front_m1;
    logic [W-1:0] v_sync_m1, v_back_m1, v_data_m1, v_front_m1;
    logic         hsync_o, vsync_o, de_o, frame_evt_o;
    logic [W-1:0] px_x_o, px_y_o;

    int errors = 0;
    int checks = 0;
    int hl[4];
    int vl[4];

    always #4 clk = ~clk;

    vtg_top dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .pol_sel(pol_sel),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1),
        .h_data_m1(h_data_m1), .h_front_m1(h_front_m1),
        .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
        .v_data_m1(v_data_m1), .v_front_m1(v_front_m1),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .px_x_o(px_x_o), .px_y_o(px_y_o), .frame_evt_o(frame_evt_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(int hs, int hb, int hd, int hf, int vs, int vb, int vd, int vf);
        hl[0] = hs; hl[1] = hb; hl[2] = hd; hl[3] = hf;
        vl[0] = vs; vl[1] = vb; vl[2] = vd; vl[3] = vf;
        h_sync_m1 = W'(hs - 1); h_back_m1 = W'(hb - 1);
        h_data_m1 = W'(hd - 1); h_front_m1 = W'(hf - 1);
        v_sync_m1 = W'(vs - 1); v_back_m1 = W'(vb - 1);
        v_data_m1 = W'(vd - 1); v_front_m1 = W'(vf - 1);
    endtask

    function automatic void locate(input int pos, input int l[4], output int ph, output int off);
        int rem = pos;
        ph = 3;
        off = 0;
        for (int i = 0; i < 4; i++) begin
            if (rem < l[i]) begin
                ph = i;
                off = rem;
                break;
            end
            rem -= l[i];
        end
    endfunction

    function automatic int lvl(bit act, bit high);
        return act ? int'(high) : int'(!high);
    endfunction

    task automatic check_idle(string req);
        check({req, " hsync idle"}, int'(hsync_o), lvl(1'b0, pol_sel[1]));
        check({req, " vsync idle"}, int'(vsync_o), lvl(1'b0, pol_sel[0]));
        check({req, " de idle"}, int'(de_o), lvl(1'b0, pol_sel[2]));
        check({req, " x idle"}, int'(px_x_o), 0);
        check({req, " y idle"}, int'(px_y_o), 0);
        check({req, " evt idle"}, int'(frame_evt_o), 0);
    endtask

    // run from position 0 for ncyc sampled cycles, checking every one
    task automatic run_check(int ncyc, logic [2:0] pol);
        int lh = hl[0] + hl[1] + hl[2] + hl[3];
        int lv = vl[0] + vl[1] + vl[2] + vl[3];
        @(negedge clk);
        pol_sel = pol;
        run_en = 1'b1;
        #1;
        for (int t = 0; t < ncyc; t++) begin
            int hp, line, hph, hoff, vph, voff;
            if (t > 0) begin
                @(negedge clk);
                #1;
            end
            hp = t % lh;
            line = (t / lh) % lv;
            locate(hp, hl, hph, hoff);
            locate(line, vl, vph, voff);
            // R1 R2 R3 R5: horizontal phase placement and level
            check("R1 R2 R3 R5 hsync", int'(hsync_o), lvl(hph == 0, pol[1]));
            // R6 R3: vertical placement and level
            check("R6 R3 vsync", int'(vsync_o), lvl(vph == 0, pol[0]));
            // R8
            check("R8 de", int'(de_o), lvl(hph == 2 && vph == 2, pol[2]));
            // R9
            check("R9 x", int'(px_x_o), (hph == 2) ? hoff : 0);
            check("R9 y", int'(px_y_o), (vph == 2) ? voff : 0);
            // R7
            check("R7 evt", int'(frame_evt_o), (hp == 0 && line == 0) ? 1 : 0);
        end
        @(negedge clk);
        run_en = 1'b0;
        #1;
        // R4: inactive in the same cycle
        check_idle("R4");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        run_en = 1'b1;
        pol_sel = 3'b111;
        set_cfg(2, 3, 4, 2, 1, 2, 3, 1);
        repeat (3) @(negedge clk);
        #1;
        // R10: outputs inactive under reset even with run_en high
        check_idle("R10");
        run_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check_idle("R4 stopped");

        // two full frames, active-high outputs
        run_check(2 * 11 * 7, 3'b111);
        // all active-low
        run_check(2 * 11 * 7, 3'b000);
        // mixed polarity, partial frame then R5 restart from the start
        run_check(40, 3'b101);
        run_check(11 * 7 + 5, 3'b010);

        // minimum lengths: every interval one unit long
        set_cfg(1, 1, 1, 1, 1, 1, 1, 1);
        run_check(3 * 16, 3'b111);

        // asymmetric lengths, longer data and porches
        set_cfg(1, 2, 6, 3, 2, 1, 4, 2);
        run_check(2 * 12 * 9, 3'b110);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule